// File: doc/BRIEF.md
# TFT Panel Timing Generator

This block drives the control lines of a digital TFT panel. It divides the system clock by two to form a shift clock, and whenever the pixel enable is high it moves one pixel position on each rising shift-clock edge. From a horizontal and a vertical position counter it decodes a line pulse, a frame pulse and a data-ready strobe. A pixel source uses the exposed position counters and the active flag to place its data inside the data-ready window.

A host programs five timing codes through a single-cycle write port. These codes set the visible width, the horizontal blanking, where the data-ready window sits, the visible height and the vertical blanking. Each written code goes into a pending copy. The pending copies are transferred to the working copies only at a frame boundary, so no frame ever mixes two timings.

Top module: `tft_timing_gen`

## Requirements
- R1: `hpos` counts 0 to HT-1 and then wraps to 0, one step per pixel. HT = (W+1)*8 + (HB+4)*8 pixels, where W is the width code and HB is the horizontal blanking code.
- R2: `vpos` moves up by one each time `hpos` wraps, over 0 to VT-1. VT = (H+1)+VB lines, where H is the height code and VB is the vertical blanking code. VT is raised to 3 when that sum is below 3.
- R3: `lp_n` is low while `hpos` is 0 to 8, which is 9 pixels at the start of every line.
- R4: `fp_n` is low from (`vpos`=0, `hpos`=18) up to, but not including, (`vpos`=2, `hpos`=18). That is two whole lines, and its falling edge comes one line period minus 18 pixels before the following `lp_n` falling edge.
- R5: On lines with `vpos` <= H, `drdy` is high for exactly (W+1)*8 pixels. It falls (E*8+16) pixels before the next `hpos`=0, where E is the effective offset code. `drdy` stays low on all other lines, and `active` always equals `drdy`.
- R6: The effective offset E is the programmed offset code, limited to at most HB+2 so that the data-ready window always fits inside the line.
- R7: `sclk` toggles on every clock in which `pix_en` is high, and pixel steps happen on its rising edge. While `pix_en` is low, `sclk`, `hpos` and `vpos` hold their values.
- R8: A write with `wr_en` high stores `wr_data` into a pending code. Address 0 holds W (7 bits), 1 holds HB (5 bits), 2 holds the offset (5 bits), 3 holds H (10 bits) and 4 holds VB (7 bits). Addresses 5 to 7 are ignored. Pending codes take effect only at the first pixel step after reset and at each wrap from the last pixel of the last line.
- R9: Reset and the cycles before the first pixel step leave `lp_n` and `fp_n` high, `drdy`, `active` and `sclk` low, and both counters at 0. The first pixel step shows position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Advance enable for the shift clock phase |
| wr_en | input | 1 | Timing code write strobe |
| wr_addr | input | 3 | Timing code select |
| wr_data | input | 10 | Timing code value |
| sclk | output | 1 | Shift clock |
| lp_n | output | 1 | Line pulse, active low |
| fp_n | output | 1 | Frame pulse, active low |
| drdy | output | 1 | Data-ready strobe |
| active | output | 1 | Active-video flag |
| hpos | output | 11 | Pixel position in the line |
| vpos | output | 11 | Line position in the frame |

## Verification
Every output changes on the same clock edge as the pixel step, which is the edge where `sclk` rises. There is no further register stage, so the bench compares all outputs against its model 1 ns after each rising clock edge. A code write becomes visible only at the next frame boundary, which may come several hundred clocks after the write. The model holds the write in its own pending copy until that boundary. Stretches of irregular `pix_en` confirm that `sclk` and the counters freeze on the exact cycles the enable is low.

// File: rtl/tft_timing_gen.sv
module tft_timing_gen #(
  parameter logic [6:0] RST_W   = 7'd1,
  parameter logic [4:0] RST_HB  = 5'd0,
  parameter logic [4:0] RST_OFF = 5'd0,
  parameter logic [9:0] RST_H   = 10'd3,
  parameter logic [6:0] RST_VB  = 7'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_en,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [9:0]  wr_data,
  output logic        sclk,
  output logic        lp_n,
  output logic        fp_n,
  output logic        drdy,
  output logic        active,
  output logic [10:0] hpos,
  output logic [10:0] vpos
);
  localparam int HW = 11;
  localparam int VW = 11;

  logic [6:0] w_p, w_a, vb_p, vb_a;
  logic [4:0] hb_p, hb_a, off_p, off_a;
  logic [9:0] h_p, h_a;
  logic run;
  logic [HW-1:0] hdisp, htot, hlim, eoff, dend, dstart;
  logic [VW-1:0] vsum, vtot;
  logic step, last_h, last_v, load;

  always_comb begin
    hdisp  = (HW'(w_a) + HW'(1)) << 3;
    htot   = hdisp + ((HW'(hb_a) + HW'(4)) << 3);
    hlim   = HW'(hb_a) + HW'(2);
    eoff   = (HW'(off_a) > hlim) ? hlim : HW'(off_a);
    dend   = htot - (eoff << 3) - HW'(16);
    dstart = dend - hdisp;
    vsum   = VW'(h_a) + VW'(1) + VW'(vb_a);
    vtot   = (vsum < VW'(3)) ? VW'(3) : vsum;
  end

  assign step   = pix_en & ~sclk;
  assign last_h = (hpos == htot - HW'(1));
  assign last_v = (vpos == vtot - VW'(1));
  assign load   = step & (~run | (last_h & last_v));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk <= 1'b0;
      run  <= 1'b0;
      hpos <= '0;
      vpos <= '0;
      w_p <= RST_W;   hb_p <= RST_HB; off_p <= RST_OFF; h_p <= RST_H; vb_p <= RST_VB;
      w_a <= RST_W;   hb_a <= RST_HB; off_a <= RST_OFF; h_a <= RST_H; vb_a <= RST_VB;
    end else begin
      if (pix_en) sclk <= ~sclk;
      if (step) begin
        run <= 1'b1;
        if (run) begin
          if (last_h) begin
            hpos <= '0;
            vpos <= last_v ? '0 : vpos + VW'(1);
          end else begin
            hpos <= hpos + HW'(1);
          end
        end
      end
      if (load) begin
        w_a <= w_p; hb_a <= hb_p; off_a <= off_p; h_a <= h_p; vb_a <= vb_p;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: w_p   <= wr_data[6:0];
          3'd1: hb_p  <= wr_data[4:0];
          3'd2: off_p <= wr_data[4:0];
          3'd3: h_p   <= wr_data;
          3'd4: vb_p  <= wr_data[6:0];
          default: ;
        endcase
      end
    end
  end

  assign lp_n   = ~(run & (hpos < HW'(9)));
  assign fp_n   = ~(run & (((vpos == VW'(0)) & (hpos >= HW'(18))) |
                           (vpos == VW'(1)) |
                           ((vpos == VW'(2)) & (hpos < HW'(18)))));
  assign drdy   = run & (vpos <= VW'(h_a)) & (hpos >= dstart) & (hpos < dend);
  assign active = drdy;

  // R1
  hstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && run && !last_h) |=> hpos == $past(hpos) + HW'(1));
  // R2
  vstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && run && last_h && !last_v) |=> (vpos == $past(vpos) + VW'(1)) && (hpos == '0));
  // R3
  lp_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lp_n) |-> hpos == '0);
  // R4
  fp_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fp_n) |-> (vpos == '0) && (hpos == HW'(18)));
  // R5
  drdy_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy) |-> vpos <= VW'(h_a));
  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(hpos) && $stable(vpos) && $stable(sclk));
endmodule

// File: tb/sim_tft_timing_gen.sv
module sim_tft_timing_gen;
  logic clk = 1'b0, rst_n = 1'b0, pix_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic sclk, lp_n, fp_n, drdy, active;
  logic [10:0] hpos, vpos;
  int errors = 0, checks = 0;
  bit done = 0;

  tft_timing_gen u0 (.clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sclk(sclk), .lp_n(lp_n), .fp_n(fp_n),
    .drdy(drdy), .active(active), .hpos(hpos), .vpos(vpos));

  always #2 clk = ~clk;

  int pend[5], act[5];
  int mh, mv, mph, mrun;
  int mask[5] = '{127, 31, 31, 1023, 127};

  function automatic int htot_f(); return (act[0]+1)*8 + (act[1]+4)*8; endfunction
  function automatic int vtot_f();
    int s = act[3] + 1 + act[4];
    return (s < 3) ? 3 : s;
  endfunction
  function automatic int dend_f();
    int e = (act[2] > act[1] + 2) ? act[1] + 2 : act[2];
    return htot_f() - (e*8 + 16);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pend = '{1, 0, 0, 3, 1};
      act = pend;
      mh = 0; mv = 0; mph = 0; mrun = 0;
    end else begin
      if (pix_en && mph == 0) begin
        if (!mrun) begin
          mrun = 1;
          act = pend;
        end else if (mh == htot_f() - 1) begin
          mh = 0;
          if (mv == vtot_f() - 1) begin
            mv = 0;
            act = pend;
          end else mv++;
        end else mh++;
      end
      if (pix_en) mph = 1 - mph;
      if (wr_en && wr_addr < 5) pend[wr_addr] = wr_data & mask[wr_addr];
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      int ds, de, lp_e, fp_e, dr_e;
      de = dend_f(); ds = de - (act[0]+1)*8;
      lp_e = !(mrun && mh < 9);
      fp_e = !(mrun && ((mv == 0 && mh >= 18) || mv == 1 || (mv == 2 && mh < 18)));
      dr_e = mrun && mv <= act[3] && mh >= ds && mh < de;
      check("R7 sclk", sclk, mph);
      check("R1 R8 hpos", hpos, mh);
      check("R2 R8 vpos", vpos, mv);
      check("R3 lp_n", lp_n, lp_e);
      check("R4 fp_n", fp_n, fp_e);
      check("R5 R6 drdy", drdy, dr_e);
      check("R5 active", active, dr_e);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = 10'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4*150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R9 reset state before any pixel step
    check("R9 lp_n", lp_n, 1); check("R9 fp_n", fp_n, 1);
    check("R9 drdy", drdy, 0); check("R9 sclk", sclk, 0);
    check("R9 hpos", hpos, 0); check("R9 vpos", vpos, 0);
    pix_en = 1;
    repeat (200) @(negedge clk);
    // R8: mid-frame writes, deferred to next frame; address 6 ignored
    wr(0, 2); wr(1, 1); wr(2, 1); wr(3, 2); wr(4, 0); wr(6, 5);
    repeat (1200) @(negedge clk);
    // R6: oversized offset clamps
    wr(1, 0); wr(2, 31); wr(3, 0); wr(4, 0);
    repeat (900) @(negedge clk);
    // R7: irregular enable
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk); pix_en = ((i * 7) % 5) != 0;
    end
    pix_en = 1;
    // R2: larger frame with blanking lines
    wr(0, 0); wr(1, 2); wr(2, 3); wr(3, 1); wr(4, 3);
    repeat (1500) @(negedge clk);
    pix_en = 0;
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule